// File: doc/BRIEF.md
# MII Link Duplex Resolver

This block polls one PHY at a programmable interval to keep a two-bit mode word current. The mode word holds a full-duplex flag and a transmit-threshold flag. Each poll goes through a simple request/response port to an MDIO master, which is outside this block.

A poll first reads the basic status register (address 1) and then the link partner ability register (address 5). An all-ones status word means no transceiver is present. A status word that shows the link down is read a second time before it is believed. With a valid link, the partner ability word is ANDed with a local advertisement word, and the result sets the speed and duplex. A restart pulse is raised only when the mode word actually changes.

Every poll ends with a one-cycle completion strobe and a two-bit result code. The code is 0 for unchanged, 1 for changed, 2 for no link and 3 for absent PHY.

Top module: `mii_duplex_poller`

## Requirements
- R1: After `poll_interval`+1 idle cycles, a poll issues a read of register 1 and then a read of register 5, both with `req_phy` equal to `phy_addr`.
- R2: A first status value of 0xFFFF ends the poll with result 3 and `phy_absent`=1. No partner read is issued, and neither mode flag nor `restart` changes.
- R3: If status bit 2 reads 0, register 1 is read once more. Result 2 with `link_up`=0 follows only if that second read also has bit 2 at 0. Otherwise resolution goes ahead with `link_up`=1.
- R4: The negotiated set is the partner word ANDed with `local_adv`. `tx_thresh` is 0 if bit 7, 8 or 9 of that set is 1, and 1 otherwise.
- R5: Full duplex results when negotiated bit 8 is 1. It also results when bit 6 is 1 while bits 7 and 9 are both 0. Every other set gives half duplex.
- R6: With `duplex_lock` high during a resolving poll, `full_duplex` becomes 1 whatever the negotiated set.
- R7: `restart` pulses for one cycle, together with `poll_done` and result 1, only when the new {tx_thresh, full_duplex} differs from the stored one. An equal word gives result 0 and no pulse.
- R8: At most one MDIO request is outstanding at a time. No new request is raised until the previous response has arrived.
- R9: After reset, `full_duplex`, `tx_thresh`, `link_up`, `phy_absent`, `restart`, `poll_done` and `req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_interval | input | CNT_W | Idle cycles between polls, minus one |
| phy_addr | input | 5 | PHY address to poll |
| local_adv | input | 16 | Local advertisement word |
| duplex_lock | input | 1 | Force full duplex |
| req_valid | output | 1 | MDIO read request |
| req_ready | input | 1 | Request accepted |
| req_phy | output | 5 | Request PHY address |
| req_reg | output | 5 | Request register address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 16 | Read data |
| full_duplex | output | 1 | Mode flag: full duplex |
| tx_thresh | output | 1 | Mode flag: transmit threshold |
| link_up | output | 1 | Last confirmed link state |
| phy_absent | output | 1 | Last poll found all-ones status |
| restart | output | 1 | One-cycle pulse on mode change |
| poll_done | output | 1 | One-cycle poll completion strobe |
| poll_result | output | 2 | 0 unchanged, 1 changed, 2 no link, 3 absent |

## Verification
A wrong read step shows up within one poll as a missing, extra or reordered register address on the request port. This makes a skipped confirmation read, or a partner read after an absent status, visible before `poll_done`. A stale stored mode word shows at the completion strobe of the very next poll. It appears as a `restart` pulse or a result code that disagrees with the expected change, or as flags that do not match the value computed from the swept advertisement, partner and lock combinations.

// File: rtl/mii_duplex_poller.sv
module mii_duplex_poller #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] poll_interval,
  input  logic [4:0]       phy_addr,
  input  logic [15:0]      local_adv,
  input  logic             duplex_lock,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [4:0]       req_phy,
  output logic [4:0]       req_reg,
  input  logic             rsp_valid,
  input  logic [15:0]      rsp_data,
  output logic             full_duplex,
  output logic             tx_thresh,
  output logic             link_up,
  output logic             phy_absent,
  output logic             restart,
  output logic             poll_done,
  output logic [1:0]       poll_result
);
  localparam logic [4:0] REG_STATUS  = 5'd1;
  localparam logic [4:0] REG_PARTNER = 5'd5;
  localparam int         LINK_BIT    = 2;

  typedef enum logic [1:0] {S_WAIT, S_REQ, S_RSP, S_EVAL} state_t;
  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       step;
  logic [15:0]      stat_q, part_q;

  wire [15:0] neg     = part_q & local_adv;
  wire        fd_new  = duplex_lock | neg[8] | (neg[6] & ~neg[7] & ~neg[9]);
  wire        thr_new = ~|neg[9:7];
  wire        absent  = (stat_q == 16'hFFFF);

  assign req_valid = (state == S_REQ);
  assign req_phy   = phy_addr;
  assign req_reg   = (step == 2'd1) ? REG_PARTNER : REG_STATUS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_WAIT;
      cnt         <= '0;
      step        <= '0;
      stat_q      <= '0;
      part_q      <= '0;
      full_duplex <= 1'b0;
      tx_thresh   <= 1'b0;
      link_up     <= 1'b0;
      phy_absent  <= 1'b0;
      restart     <= 1'b0;
      poll_done   <= 1'b0;
      poll_result <= 2'd0;
    end else begin
      restart   <= 1'b0;
      poll_done <= 1'b0;
      case (state)
        S_WAIT: begin
          if (cnt >= poll_interval) begin
            cnt   <= '0;
            step  <= 2'd0;
            state <= S_REQ;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REQ: if (req_ready) state <= S_RSP;
        S_RSP: begin
          if (rsp_valid) begin
            case (step)
              2'd0: begin
                stat_q <= rsp_data;
                if (rsp_data == 16'hFFFF) state <= S_EVAL;
                else begin step <= 2'd1; state <= S_REQ; end
              end
              2'd1: begin
                part_q <= rsp_data;
                if (stat_q[LINK_BIT]) state <= S_EVAL;
                else begin step <= 2'd2; state <= S_REQ; end
              end
              default: begin
                stat_q <= rsp_data;
                state  <= S_EVAL;
              end
            endcase
          end
        end
        default: begin
          poll_done  <= 1'b1;
          state      <= S_WAIT;
          phy_absent <= absent;
          if (absent) begin
            poll_result <= 2'd3;
          end else if (!stat_q[LINK_BIT]) begin
            link_up     <= 1'b0;
            poll_result <= 2'd2;
          end else begin
            link_up <= 1'b1;
            if ({thr_new, fd_new} != {tx_thresh, full_duplex}) begin
              full_duplex <= fd_new;
              tx_thresh   <= thr_new;
              restart     <= 1'b1;
              poll_result <= 2'd1;
            end else begin
              poll_result <= 2'd0;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mii_duplex_poller_chk.sv
module mii_duplex_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       duplex_lock,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       full_duplex,
  input logic       tx_thresh,
  input logic       restart,
  input logic       poll_done,
  input logic [1:0] poll_result
);
  logic [1:0] outs;
  always_ff @(posedge clk) begin
    if (!rst_n) outs <= '0;
    else outs <= outs + {1'b0, req_valid & req_ready} - {1'b0, rsp_valid & (outs != 2'd0)};
  end

  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> outs == 2'd0);
  a_r7_restart_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (full_duplex != $past(full_duplex)) || (tx_thresh != $past(tx_thresh)));
  a_r7_change_means_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ((full_duplex != $past(full_duplex)) || (tx_thresh != $past(tx_thresh))) |-> restart);
  a_r7_restart_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> poll_done && poll_result == 2'd1);
  a_r2_absent_holds_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_done && poll_result == 2'd3) |-> !restart);
  a_r6_lock_forces_full: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_done && poll_result[1] == 1'b0 && $past(duplex_lock)) |-> full_duplex);
endmodule

bind mii_duplex_poller mii_duplex_poller_chk chk_i (
  .clk(clk), .rst_n(rst_n), .duplex_lock(duplex_lock), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .full_duplex(full_duplex),
  .tx_thresh(tx_thresh), .restart(restart), .poll_done(poll_done),
  .poll_result(poll_result)
);

// File: tb/mii_duplex_poller_tb.sv
module mii_duplex_poller_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] poll_interval = 16'd3;
  logic [4:0]  phy_addr = 5'd9;
  logic [15:0] local_adv = 16'h0000;
  logic        duplex_lock = 0;
  logic        req_valid, req_ready, rsp_valid;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] rsp_data;
  logic        full_duplex, tx_thresh, link_up, phy_absent, restart, poll_done;
  logic [1:0]  poll_result;

  always #2 clk = ~clk;

  mii_duplex_poller #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .poll_interval(poll_interval), .phy_addr(phy_addr),
    .local_adv(local_adv), .duplex_lock(duplex_lock), .req_valid(req_valid),
    .req_ready(req_ready), .req_phy(req_phy), .req_reg(req_reg),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .full_duplex(full_duplex),
    .tx_thresh(tx_thresh), .link_up(link_up), .phy_absent(phy_absent),
    .restart(restart), .poll_done(poll_done), .poll_result(poll_result)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] st_a, st_b, lpa_v;
  int n_st, n_lp, n_bad, first_reg;
  logic pend;
  logic [4:0] pend_reg;
  logic exp_fd = 0, exp_thr = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    req_ready = 1; rsp_valid = 0; rsp_data = 0; pend = 0;
    n_st = 0; n_lp = 0; n_bad = 0; first_reg = -1;
    st_a = 0; st_b = 0; lpa_v = 0; pend_reg = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (pend) begin
        pend = 0;
        rsp_valid = 1;
        if (pend_reg == 5'd5) rsp_data = lpa_v;
        else rsp_data = (n_st == 1) ? st_a : st_b;
      end else if (req_valid && rst_n) begin
        pend = 1;
        pend_reg = req_reg;
        if (first_reg < 0) first_reg = req_reg;
        if (req_phy != phy_addr) n_bad++;
        if (req_reg == 5'd1) n_st++;
        else if (req_reg == 5'd5) n_lp++;
        else n_bad++;
      end else if (req_valid) n_bad++;
    end
  end

  task automatic run_poll(input logic [15:0] s1, input logic [15:0] s2,
                          input logic [15:0] lp, input logic [15:0] adv,
                          input logic lock, output logic [1:0] res,
                          output logic rs);
    st_a = s1; st_b = s2; lpa_v = lp; local_adv = adv; duplex_lock = lock;
    n_st = 0; n_lp = 0; n_bad = 0; first_reg = -1;
    res = 2'bxx; rs = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (poll_done) begin res = poll_result; rs = restart; break; end
    end
  endtask

  initial begin
    logic [1:0] res;
    logic       rs;
    logic [15:0] neg;
    logic efd, ethr;
    fork
      begin
        repeat (3) @(negedge clk);
        check("R9 full_duplex", full_duplex, 0);
        check("R9 tx_thresh", tx_thresh, 0);
        check("R9 link_up", link_up, 0);
        check("R9 phy_absent", phy_absent, 0);
        check("R9 req_valid", req_valid, 0);
        check("R9 restart/poll_done", {restart, poll_done}, 0);
        rst_n = 1;

        run_poll(16'hFFFF, 16'h0004, 16'h01E0, 16'h01E1, 0, res, rs);
        check("R2 result", res, 3);
        check("R2 phy_absent", phy_absent, 1);
        check("R2 no partner read", n_lp, 0);
        check("R2 flags", {restart, full_duplex, tx_thresh}, {1'b0, exp_fd, exp_thr});

        run_poll(16'h0000, 16'h0000, 16'h01E0, 16'h01E1, 0, res, rs);
        check("R3 result no link", res, 2);
        check("R3 link_up", link_up, 0);
        check("R3 status reads", n_st, 2);
        check("R1 order/phy", {first_reg[4:0], n_lp[4:0], n_bad[4:0]}, {5'd1, 5'd1, 5'd0});
        check("R2 absent cleared", phy_absent, 0);

        run_poll(16'h0000, 16'h0004, 16'h0100, 16'h01E1, 0, res, rs);
        exp_fd = 1; exp_thr = 0;
        check("R3 recovered result", res, 1);
        check("R3 link_up", link_up, 1);
        check("R3 status reads", n_st, 2);
        check("R7 restart", rs, 1);

        for (int l = 0; l < 2; l++)
          for (int a = 0; a < 16; a++)
            for (int p = 0; p < 16; p++) begin
              logic [15:0] av, pv;
              av = 16'(a) << 6; pv = 16'(p) << 6;
              run_poll(16'h782D, 16'h782D, pv, av, l[0], res, rs);
              neg = av & pv;
              efd = l[0] | neg[8] | (neg[6] & ~neg[7] & ~neg[9]);
              ethr = ~|neg[9:7];
              check("R1 one status one partner, phy", {n_st[3:0], n_lp[3:0], n_bad[3:0], first_reg[3:0]}, {4'd1, 4'd1, 4'd0, 4'd1});
              check("R8 no overlapping request", n_bad, 0);
              check("R5 R6 full_duplex", full_duplex, efd);
              check("R4 tx_thresh", tx_thresh, ethr);
              check("R7 result", res, ({ethr, efd} != {exp_thr, exp_fd}) ? 2'd1 : 2'd0);
              check("R7 restart", rs, ({ethr, efd} != {exp_thr, exp_fd}));
              exp_fd = efd; exp_thr = ethr;
            end

        run_poll(16'h782D, 16'h782D, 16'h0040, 16'h0040, 0, res, rs);
        run_poll(16'h782D, 16'h782D, 16'h0040, 16'h0040, 0, res, rs);
        check("R7 repeat unchanged", {res, rs}, 3'b000);
      end
      begin
        repeat (150000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule